// File: doc/BRIEF.md
# Barrel Shifter with Condition Flags

This block is the operand shifter of a load/store processor datapath. A single-cycle combinational path applies one of five operations to the operand: shift left, logical shift right, arithmetic shift right, rotate right, or a one-place rotate through the carry. The shift count comes either from a short immediate field or from the least significant byte of a register value. The shifted value appears at `result` in the same cycle.

A small flag register holds the negative, zero and carry flags. The carry it holds is also the incoming carry for the current operation. It is used by the rotate-through-carry and by any operation whose count is zero. The register loads new flags at a clock edge only when `flag_upd` is high. Otherwise it keeps its contents. The carry produced is always the last bit that left the operand.

Top module: `shift_flag_unit`

## Requirements
- R1: `op_sel` encodes the operation as 0 = shift left, 1 = logical shift right, 2 = arithmetic shift right, 3 = rotate right, 4 = rotate right through carry. Codes 5, 6 and 7 return the operand unchanged and give a carry equal to the held carry.
- R2: With `amt_src` = 1 the count is bits [7:0] of `amt_reg`, and the upper bits of `amt_reg` and all of `amt_imm` are ignored. With `amt_src` = 0 the count is `amt_imm` (log2 WIDTH bits wide), and `amt_reg` is ignored.
- R3: Shift left by n, for 1 ≤ n < WIDTH, gives the operand moved up n places with zeros below, and carry = operand[WIDTH-n]. For n = WIDTH the result is zero and carry = operand[0]. For n > WIDTH the result and carry are both zero.
- R4: Logical shift right by n, for 1 ≤ n < WIDTH, gives zero fill from the top, and carry = operand[n-1]. For n = WIDTH the result is zero and carry = operand[WIDTH-1]. For n > WIDTH the result and carry are both zero.
- R5: Arithmetic shift right fills the vacated top bits with the original operand[WIDTH-1], and carry = operand[n-1] for n < WIDTH. For n ≥ WIDTH every result bit and the carry equal operand[WIDTH-1].
- R6: Rotate right by n uses n modulo WIDTH and loses no bits: bits leaving bit 0 re-enter at bit WIDTH-1, and carry = result[WIDTH-1]. A nonzero multiple of WIDTH returns the operand with carry = operand[WIDTH-1].
- R7: Rotate right through carry ignores the count. It gives {held carry, operand[WIDTH-1:1]} and a carry of operand[0].
- R8: A count of zero for operations 0 to 3 returns the operand unchanged and gives a carry equal to the held carry.
- R9: When `flag_upd` is high at a rising clock edge, the flag register loads N = result[WIDTH-1], Z = 1 exactly when the result is all zeros, and C = the carry of the operation.
- R10: While `flag_upd` is low, N, Z and C keep their values across the clock edge. Reset (active low) clears all three flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| operand | input | WIDTH | Value to be shifted or rotated |
| op_sel | input | 3 | Operation code (see R1) |
| amt_src | input | 1 | 1: count from register byte, 0: count from immediate |
| amt_imm | input | log2(WIDTH) | Immediate shift count |
| amt_reg | input | REG_W | Register value whose low byte is the count |
| flag_upd | input | 1 | Load the flag register at the next edge |
| result | output | WIDTH | Shifted or rotated value |
| flag_n | output | 1 | Held negative flag |
| flag_z | output | 1 | Held zero flag |
| flag_c | output | 1 | Held carry flag, also the incoming carry |

## Verification
The bench builds the unit with WIDTH = 8 and REG_W = 16. With these values every operand value can be combined with every operation code and with counts on both sides of the width: zero, each count below 8, exactly 8, just above, and large byte values of 16, 200 and 255. The 16-bit count register carries unrelated upper bits, and the unused immediate is driven with a different value, so a selector that reads the wrong bits shows up at once. The flag-update enable changes from vector to vector, which exercises both the hold and the load of the flags against a carry that keeps changing.

// File: rtl/shift_pkg.sv
package shift_pkg;

   // byte of the count register that holds the shift amount
   localparam int CNT_W = 8;

   typedef enum logic [2:0] {
      SH_LSL = 3'd0,
      SH_LSR = 3'd1,
      SH_ASR = 3'd2,
      SH_ROR = 3'd3,
      SH_RRX = 3'd4
   } shift_op_e;

endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel
   import shift_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int REG_W = 32,
   localparam int IMM_W = $clog2(WIDTH)
) (
   input  logic             amt_src,
   input  logic [IMM_W-1:0] amt_imm,
   input  logic [REG_W-1:0] amt_reg,
   output logic [CNT_W-1:0] cnt
);

   logic [CNT_W-1:0] imm_ext;

   assign imm_ext = CNT_W'(amt_imm);

   // only the low byte of the register counts
   generate
      if (REG_W > CNT_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^amt_reg[REG_W-1:CNT_W];
      end
   endgenerate

   assign cnt = amt_src ? amt_reg[CNT_W-1:0] : imm_ext;

endmodule

// File: rtl/ror_barrel.sv
module ror_barrel #(
   parameter int WIDTH = 32,
   localparam int STAGES = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0]  din,
   input  logic [STAGES-1:0] amt,
   output logic [WIDTH-1:0]  dout
);

   logic [WIDTH-1:0] stage [0:STAGES];

   assign stage[0] = din;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         localparam int K = 2 ** s;
         assign stage[s+1] = amt[s] ? {stage[s][K-1:0], stage[s][WIDTH-1:K]}
                                    : stage[s];
      end
   endgenerate

   assign dout = stage[STAGES];

endmodule

// File: rtl/shift_core.sv
module shift_core
   import shift_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int IMM_W = $clog2(WIDTH)
) (
   input  logic [2:0]       op,
   input  logic [WIDTH-1:0] a,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cin,
   output logic [WIDTH-1:0] res,
   output logic             cout
);

   logic        [WIDTH:0]   lsl_x;
   logic        [WIDTH:0]   lsr_x;
   logic signed [WIDTH:0]   asr_x;
   logic        [WIDTH-1:0] ror_v;
   logic                    cnt_zero;

   assign cnt_zero = (cnt == '0);

   // one spare bit on the exit side catches the last bit shifted out
   assign lsl_x = {1'b0, a} << cnt;
   assign lsr_x = {a, 1'b0} >> cnt;
   assign asr_x = $signed({a, 1'b0}) >>> cnt;

   ror_barrel #(.WIDTH(WIDTH)) u_ror (
      .din  (a),
      .amt  (cnt[IMM_W-1:0]),
      .dout (ror_v)
   );

   always_comb begin
      res  = a;
      cout = cin;
      unique case (op)
         SH_LSL: if (!cnt_zero) begin
            res  = lsl_x[WIDTH-1:0];
            cout = lsl_x[WIDTH];
         end
         SH_LSR: if (!cnt_zero) begin
            res  = lsr_x[WIDTH:1];
            cout = lsr_x[0];
         end
         SH_ASR: if (!cnt_zero) begin
            res  = asr_x[WIDTH:1];
            cout = asr_x[0];
         end
         SH_ROR: if (!cnt_zero) begin
            res  = ror_v;
            cout = ror_v[WIDTH-1];
         end
         SH_RRX: begin
            res  = {cin, a[WIDTH-1:1]};
            cout = a[0];
         end
         default: begin
            res  = a;
            cout = cin;
         end
      endcase
   end

endmodule

// File: rtl/flag_reg.sv
module flag_reg #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [WIDTH-1:0] res,
   input  logic             cout,
   output logic             n_q,
   output logic             z_q,
   output logic             c_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q <= 1'b0;
         z_q <= 1'b0;
         c_q <= 1'b0;
      end else if (upd) begin
         n_q <= res[WIDTH-1];
         z_q <= (res == '0);
         c_q <= cout;
      end
   end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
   import shift_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int REG_W = 32,
   localparam int IMM_W = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] operand,
   input  logic [2:0]       op_sel,
   input  logic             amt_src,
   input  logic [IMM_W-1:0] amt_imm,
   input  logic [REG_W-1:0] amt_reg,
   input  logic             flag_upd,
   output logic [WIDTH-1:0] result,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c
);

   generate
      if (WIDTH < 4 || WIDTH > 128 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("shift_flag_unit: WIDTH must be a power of two in 4..128");
      end
      if (REG_W < CNT_W) begin : g_bad_reg
         $error("shift_flag_unit: REG_W must hold the count byte");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             carry_out;

   shift_amt_sel #(.WIDTH(WIDTH), .REG_W(REG_W)) u_sel (
      .amt_src (amt_src),
      .amt_imm (amt_imm),
      .amt_reg (amt_reg),
      .cnt     (cnt)
   );

   shift_core #(.WIDTH(WIDTH)) u_core (
      .op   (op_sel),
      .a    (operand),
      .cnt  (cnt),
      .cin  (flag_c),
      .res  (result),
      .cout (carry_out)
   );

   flag_reg #(.WIDTH(WIDTH)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (flag_upd),
      .res   (result),
      .cout  (carry_out),
      .n_q   (flag_n),
      .z_q   (flag_z),
      .c_q   (flag_c)
   );

endmodule

// File: rtl/shift_flag_chk.sv
module shift_flag_chk
   import shift_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int REG_W = 32,
   localparam int IMM_W = $clog2(WIDTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] operand,
   input logic [2:0]       op_sel,
   input logic             amt_src,
   input logic [IMM_W-1:0] amt_imm,
   input logic [REG_W-1:0] amt_reg,
   input logic             flag_upd,
   input logic [WIDTH-1:0] result,
   input logic             flag_n,
   input logic             flag_z,
   input logic             flag_c
);

   logic [CNT_W-1:0] cnt_seen;
   assign cnt_seen = amt_src ? amt_reg[CNT_W-1:0] : CNT_W'(amt_imm);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_upd |=> $stable({flag_n, flag_z, flag_c}));

   p_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_upd |=> flag_n == $past(result[WIDTH-1]));

   p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_upd |=> flag_z == ($past(result) == '0));

   p_rrx_res_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == SH_RRX) |-> result == {flag_c, operand[WIDTH-1:1]});

   p_rrx_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_upd && op_sel == SH_RRX) |=> flag_c == $past(operand[0]));

   p_cnt0_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel < 3'd4 && cnt_seen == '0) |-> result == operand);

   p_cnt0_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel < 3'd4 && cnt_seen == '0) |=> flag_c == $past(flag_c));

   p_ror_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == SH_ROR) |-> $countones(result) == $countones(operand));

   p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > 3'd4) |-> result == operand);

endmodule

bind shift_flag_unit shift_flag_chk #(.WIDTH(WIDTH), .REG_W(REG_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .operand  (operand),
   .op_sel   (op_sel),
   .amt_src  (amt_src),
   .amt_imm  (amt_imm),
   .amt_reg  (amt_reg),
   .flag_upd (flag_upd),
   .result   (result),
   .flag_n   (flag_n),
   .flag_z   (flag_z),
   .flag_c   (flag_c)
);

// File: tb/sim_shift_flag_unit.sv
`timescale 1ns/1ps
module sim_shift_flag_unit;

   localparam int W  = 8;
   localparam int RW = 16;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  operand = '0;
   logic [2:0]    op_sel = '0;
   logic          amt_src = 1'b0;
   logic [IW-1:0] amt_imm = '0;
   logic [RW-1:0] amt_reg = '0;
   logic          flag_upd = 1'b0;
   logic [W-1:0]  result;
   logic          flag_n, flag_z, flag_c;

   int n_checks = 0;
   int n_fail   = 0;

   logic m_n = 1'b0, m_z = 1'b0, m_c = 1'b0;

   always #4 clk = ~clk;

   shift_flag_unit #(.WIDTH(W), .REG_W(RW)) u0 (
      .clk(clk), .rst_n(rst_n), .operand(operand), .op_sel(op_sel),
      .amt_src(amt_src), .amt_imm(amt_imm), .amt_reg(amt_reg),
      .flag_upd(flag_upd), .result(result),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: op=%0d a=%02h src=%0b imm=%0d reg=%04h actual=%0h expected=%0h",
                  tag, op_sel, operand, amt_src, amt_imm, amt_reg, act, exp);
      end
   endtask

   // returns {carry, result} from the requirement text
   function automatic logic [W:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                        input int n, input logic cin);
      logic [W-1:0] r;
      logic         c;
      r = a;
      c = cin;
      if (op == 3'd4) begin                      // R7
         for (int i = 0; i < W - 1; i++) r[i] = a[i+1];
         r[W-1] = cin;
         c = a[0];
      end else if (op < 3'd4 && n != 0) begin
         case (op)
            3'd0: begin                          // R3
               for (int i = 0; i < W; i++) r[i] = (i - n >= 0) ? a[i-n] : 1'b0;
               c = (n <= W) ? a[W-n] : 1'b0;
            end
            3'd1: begin                          // R4
               for (int i = 0; i < W; i++) r[i] = (i + n < W) ? a[i+n] : 1'b0;
               c = (n <= W) ? a[n-1] : 1'b0;
            end
            3'd2: begin                          // R5
               for (int i = 0; i < W; i++) r[i] = (i + n < W) ? a[i+n] : a[W-1];
               c = (n < W) ? a[n-1] : a[W-1];
            end
            default: begin                       // R6
               for (int i = 0; i < W; i++) r[i] = a[(i + n) % W];
               c = r[W-1];
            end
         endcase
      end
      return {c, r};
   endfunction

   function automatic string op_tag(input logic [2:0] op, input int n);
      if (op > 3'd4) return "R1";
      if (op == 3'd4) return "R7";
      if (n == 0) return "R8";
      case (op)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input int n,
                        input logic src, input logic [7:0] junk, input logic upd);
      logic [W:0] e;
      string      tag;
      @(negedge clk);
      op_sel   = op;
      operand  = a;
      amt_src  = src;
      flag_upd = upd;
      if (src) begin
         amt_reg = {junk, 8'(n)};
         amt_imm = ~IW'(n);
      end else begin
         amt_imm = IW'(n);
         amt_reg = {junk, 8'(n) ^ 8'h3C};
      end
      #1;
      e   = model(op, a, n, m_c);
      tag = op_tag(op, n);
      if (src) tag = {tag, "+R2"};
      else     tag = {tag, "+R2imm"};
      check(tag, 32'(result), 32'(e[W-1:0]));
      @(posedge clk);
      #1;
      if (upd) begin
         m_n = e[W-1];
         m_z = (e[W-1:0] == '0);
         m_c = e[W];
         check("R9", {30'd0, flag_n, flag_z}, {30'd0, m_n, m_z});
         check(tag, 32'(flag_c), 32'(m_c));
      end else begin
         check("R10", {29'd0, flag_n, flag_z, flag_c}, {29'd0, m_n, m_z, m_c});
      end
   endtask

   initial begin
      int cnts [13] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 16, 200, 255};
      repeat (3) @(posedge clk);
      #1;
      check("R10", {29'd0, flag_n, flag_z, flag_c}, 32'd0);  // reset state
      @(negedge clk);
      rst_n = 1'b1;
      for (int op = 0; op < 8; op++) begin
         for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 13; k++) begin
               logic src;
               logic upd;
               src = (cnts[k] >= 8) ? 1'b1 : a[1];
               upd = a[0] ^ k[0] ^ op[0] ^ a[3];
               apply(3'(op), 8'(a), cnts[k], src, 8'(a * 7 + k + 1), upd);
            end
         end
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(8ns * 190000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule